// File: doc/BRIEF.md
# Cache Write Ordering Gate

This block decides, one request at a time, whether a write headed for an on-chip cache line may commit now or must be held back. It watches two things on the external side. The first is a count of external bus write cycles that have been issued but not yet completed. The second is an active-low flag from the system that reports whether the external write path has drained. Each cache write request comes with its address and the coherence state of the target line. From these inputs the block raises either a commit enable or a stall request to the pipeline.

Two ordering rules apply. First, no cache write may overtake an external write issued before it, so every cache write waits until the outstanding count is zero. Second, a write to a line held exclusive or modified waits while the most recently sampled drain flag reports pending writes. A bank of programmable address regions can lift both rules: a write whose address falls inside an enabled weak-ordering region commits at once.

The decision is registered. A request presented before a clock edge is answered on the commit and stall outputs after that edge, and the answer is held for one cycle.

Top module: `wr_order_gate`

## Requirements
- R1: After synchronous reset, commit_en and stall are both 0, the outstanding-write count is zero, and the drain flag is taken as asserted (drained). A modified-line write issued straight after reset therefore commits.
- R2: Each output is registered. One cycle after a clock edge at which req_valid was 1, exactly one of commit_en and stall is 1. After an edge with req_valid 0, both are 0.
- R3: A request that matches no weak region stalls while the outstanding external write count is non-zero, whatever its line state and whatever the drain flag says.
- R4: ext_empty_n is captured only at edges where bus_wr_cycle is 1. The captured value is held until the next such edge, and changes on ext_empty_n at other times have no effect on decisions.
- R5: A request to a line in exclusive (req_line_state 2'b10) or modified (2'b11) state stalls while the last captured ext_empty_n was 1 (writes pending).
- R6: A request to a line in invalid (2'b00) or shared (2'b01) state ignores the drain flag and commits when no external writes are outstanding.
- R7: A request whose address lies in an enabled weak-ordering region commits, even with external writes outstanding and the drain flag deasserted.
- R8: A region matches when (req_addr & mask) equals (base & mask). A matching region whose weak bit is 0 does not relax ordering.
- R9: The outstanding count rises by one on bus_wr_issue, falls by one on bus_wr_done, and stays unchanged when both occur in the same cycle. It neither wraps below zero nor above its maximum (2^CNT_W-1).
- R10: A configuration write (cfg_we) loads base, mask and weak bit into entry cfg_idx. The new values apply to requests from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_empty_n | input | 1 | Active-low flag: external write path drained |
| bus_wr_cycle | input | 1 | An external write cycle (memory or I/O) is in progress; drain flag is sampled |
| bus_wr_issue | input | 1 | One external write cycle issued this cycle |
| bus_wr_done | input | 1 | One external write cycle completed this cycle |
| req_valid | input | 1 | Cache write request present |
| req_addr | input | ADDR_W | Request address |
| req_line_state | input | 2 | Target line state: 00 invalid, 01 shared, 10 exclusive, 11 modified |
| cfg_we | input | 1 | Region entry write strobe |
| cfg_idx | input | IDX_W | Region entry to write |
| cfg_base | input | ADDR_W | Region base address |
| cfg_mask | input | ADDR_W | Region compare mask (1 = bit compared) |
| cfg_weak | input | 1 | Region weak-ordering enable |
| commit_en | output | 1 | Registered: the request commits |
| stall | output | 1 | Registered: the request is held, pipeline must stall |

## Verification
The bench builds the block with eight regions over a 32-bit address and a 2-bit outstanding counter. The narrow counter lets a handful of bus issues drive the count to its ceiling, so the bench can tell saturation apart from wrap-around. With eight entries, one enabled region and one disabled region sit side by side, and a near-miss address just outside the enabled mask can be tried.

// File: rtl/wog_pkg.sv
package wog_pkg;

  typedef enum logic [1:0] {
    LINE_INV  = 2'b00,
    LINE_SHR  = 2'b01,
    LINE_EXCL = 2'b10,
    LINE_MOD  = 2'b11
  } line_state_e;

  // Lines held exclusively (clean or dirty) are the ones gated on the drain flag.
  function automatic logic owns_line(input logic [1:0] st);
    return (st == LINE_EXCL) || (st == LINE_MOD);
  endfunction

endpackage

// File: rtl/wog_region_table.sv
module wog_region_table #(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic              cfg_weak,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              weak_hit
);

  logic [NUM_REGIONS-1:0] entry_hit;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_entry
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] mask_q;
    logic              weak_q;
    logic              sel;

    assign sel = cfg_we && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q <= '0;
        mask_q <= '0;
        weak_q <= 1'b0;
      end else if (sel) begin
        base_q <= cfg_base;
        mask_q <= cfg_mask;
        weak_q <= cfg_weak;
      end
    end

    assign entry_hit[g] = weak_q && ((lookup_addr & mask_q) == (base_q & mask_q));
  end

  assign weak_hit = |entry_hit;

endmodule

// File: rtl/wog_wr_tracker.sv
module wog_wr_tracker #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_issue,
  input  logic             wr_done,
  input  logic             sample_en,
  input  logic             empty_n,
  output logic [CNT_W-1:0] outstanding,
  output logic             none_pending,
  output logic             empty_seen
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= '0;
    end else begin
      unique case ({wr_issue, wr_done})
        2'b10: if (outstanding != CNT_MAX) outstanding <= outstanding + CNT_ONE;
        2'b01: if (outstanding != '0)      outstanding <= outstanding - CNT_ONE;
        default: outstanding <= outstanding;
      endcase
    end
  end

  // Drain flag: captured only while an external write cycle is on the bus.
  always_ff @(posedge clk) begin
    if (rst)            empty_seen <= 1'b1;
    else if (sample_en) empty_seen <= ~empty_n;
  end

  assign none_pending = (outstanding == '0);

endmodule

// File: rtl/wog_decide.sv
module wog_decide
  import wog_pkg::*;
(
  input  logic       req_valid,
  input  logic [1:0] line_state,
  input  logic       weak_hit,
  input  logic       none_pending,
  input  logic       empty_seen,
  output logic       commit_c,
  output logic       stall_c
);

  logic order_block;
  logic drain_block;

  always_comb begin
    order_block = !none_pending;
    drain_block = owns_line(line_state) && !empty_seen;
    stall_c     = req_valid && !weak_hit && (order_block || drain_block);
    commit_c    = req_valid && !stall_c;
  end

endmodule

// File: rtl/wr_order_gate.sv
module wr_order_gate #(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 8,
  parameter int CNT_W       = 4,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_empty_n,
  input  logic              bus_wr_cycle,
  input  logic              bus_wr_issue,
  input  logic              bus_wr_done,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_line_state,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic              cfg_weak,
  output logic              commit_en,
  output logic              stall
);

  logic             weak_hit;
  logic [CNT_W-1:0] outstanding;
  logic             none_pending;
  logic             empty_seen;
  logic             commit_c;
  logic             stall_c;

  wog_region_table #(
    .ADDR_W      (ADDR_W),
    .NUM_REGIONS (NUM_REGIONS),
    .IDX_W       (IDX_W)
  ) u_regions (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_idx     (cfg_idx),
    .cfg_base    (cfg_base),
    .cfg_mask    (cfg_mask),
    .cfg_weak    (cfg_weak),
    .lookup_addr (req_addr),
    .weak_hit    (weak_hit)
  );

  wog_wr_tracker #(
    .CNT_W (CNT_W)
  ) u_tracker (
    .clk          (clk),
    .rst          (rst),
    .wr_issue     (bus_wr_issue),
    .wr_done      (bus_wr_done),
    .sample_en    (bus_wr_cycle),
    .empty_n      (ext_empty_n),
    .outstanding  (outstanding),
    .none_pending (none_pending),
    .empty_seen   (empty_seen)
  );

  wog_decide u_decide (
    .req_valid    (req_valid),
    .line_state   (req_line_state),
    .weak_hit     (weak_hit),
    .none_pending (none_pending),
    .empty_seen   (empty_seen),
    .commit_c     (commit_c),
    .stall_c      (stall_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_en <= 1'b0;
      stall     <= 1'b0;
    end else begin
      commit_en <= commit_c;
      stall     <= stall_c;
    end
  end

endmodule

// File: rtl/wog_checker.sv
module wog_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ext_empty_n,
  input logic             bus_wr_cycle,
  input logic             bus_wr_issue,
  input logic             bus_wr_done,
  input logic             req_valid,
  input logic             commit_en,
  input logic             stall,
  input logic             weak_hit,
  input logic             empty_seen,
  input logic [CNT_W-1:0] outstanding
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_excl_out_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({commit_en, stall}));

  p_answer_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (commit_en || stall));

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!commit_en && !stall));

  p_order_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !weak_hit && outstanding != '0) |=> stall);

  p_hold_flag_r4: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_cycle |=> $stable(empty_seen));

  p_take_flag_r4: assert property (@(posedge clk) disable iff (rst)
    bus_wr_cycle |=> (empty_seen == !$past(ext_empty_n)));

  p_weak_commit_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && weak_hit) |=> commit_en);

  p_cnt_up_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_issue && !bus_wr_done && outstanding != TOP) |=> (outstanding == $past(outstanding) + ONE));

  p_cnt_down_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_done && !bus_wr_issue && outstanding != '0) |=> (outstanding == $past(outstanding) - ONE));

  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_done && !bus_wr_issue && outstanding == '0) |=> (outstanding == '0));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_issue && !bus_wr_done && outstanding == TOP) |=> (outstanding == TOP));

endmodule

bind wr_order_gate wog_checker #(.CNT_W(CNT_W)) u_wog_chk (
  .clk          (clk),
  .rst          (rst),
  .ext_empty_n  (ext_empty_n),
  .bus_wr_cycle (bus_wr_cycle),
  .bus_wr_issue (bus_wr_issue),
  .bus_wr_done  (bus_wr_done),
  .req_valid    (req_valid),
  .commit_en    (commit_en),
  .stall        (stall),
  .weak_hit     (weak_hit),
  .empty_seen   (empty_seen),
  .outstanding  (outstanding)
);

// File: tb/tb_wr_order_gate.sv
`timescale 1ns/1ps
module tb_wr_order_gate;

  localparam int ADDR_W = 32;
  localparam int NREG   = 8;
  localparam int CW     = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ext_empty_n = 1'b0;
  logic              bus_wr_cycle = 1'b0;
  logic              bus_wr_issue = 1'b0;
  logic              bus_wr_done = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_line_state = 2'b00;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_idx = '0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [ADDR_W-1:0] cfg_mask = '0;
  logic              cfg_weak = 1'b0;
  logic              commit_en;
  logic              stall;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wr_order_gate #(.ADDR_W(ADDR_W), .NUM_REGIONS(NREG), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .ext_empty_n(ext_empty_n), .bus_wr_cycle(bus_wr_cycle),
    .bus_wr_issue(bus_wr_issue), .bus_wr_done(bus_wr_done), .req_valid(req_valid),
    .req_addr(req_addr), .req_line_state(req_line_state), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_weak(cfg_weak),
    .commit_en(commit_en), .stall(stall)
  );

  // {empty_n latched, line state, address, expected commit}
  localparam logic [35:0] VEC [9] = '{
    {1'b0, 2'b00, 32'h0000_0100, 1'b1},  // R6 drained, invalid
    {1'b1, 2'b00, 32'h0000_0100, 1'b1},  // R6 pending, invalid
    {1'b1, 2'b01, 32'h0000_0200, 1'b1},  // R6 pending, shared
    {1'b1, 2'b10, 32'h0000_0300, 1'b0},  // R5 pending, exclusive
    {1'b1, 2'b11, 32'h0000_0400, 1'b0},  // R5 pending, modified
    {1'b0, 2'b11, 32'h0000_0400, 1'b1},  // R5 drained, modified
    {1'b1, 2'b11, 32'h0000_8ABC, 1'b1},  // R7 weak region
    {1'b1, 2'b11, 32'h0001_0020, 1'b0},  // R8 region with weak bit 0
    {1'b1, 2'b10, 32'h0000_9000, 1'b0}   // R8 just outside mask
  };

  task automatic chk(input string tag, input logic ec, input logic es);
    checks++;
    if (commit_en !== ec || stall !== es) begin
      errors++;
      $display("FAIL %s: commit=%0b stall=%0b expected commit=%0b stall=%0b",
               tag, commit_en, stall, ec, es);
    end
  endtask

  task automatic latch_empty(input logic v);
    bus_wr_cycle = 1'b1; ext_empty_n = v;
    @(negedge clk);
    bus_wr_cycle = 1'b0; ext_empty_n = ~v;
  endtask

  task automatic do_req(input logic [31:0] a, input logic [1:0] s);
    req_valid = 1'b1; req_addr = a; req_line_state = s;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_issue(input int n);
    bus_wr_issue = 1'b1; repeat (n) @(negedge clk); bus_wr_issue = 1'b0;
  endtask

  task automatic pulse_done(input int n);
    bus_wr_done = 1'b1; repeat (n) @(negedge clk); bus_wr_done = 1'b0;
  endtask

  task automatic cfg(input int idx, input logic [31:0] b, input logic [31:0] m, input logic w);
    cfg_we = 1'b1; cfg_idx = idx[2:0]; cfg_base = b; cfg_mask = m; cfg_weak = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset outputs", 1'b0, 1'b0);
    do_req(32'h40, 2'b11);
    chk("R1 drained after reset", 1'b1, 1'b0);
    @(negedge clk);

    cfg(0, 32'h0000_8000, 32'hFFFF_F000, 1'b1);
    cfg(3, 32'h0001_0000, 32'hFFFF_0000, 1'b0);

    for (int i = 0; i < 9; i++) begin
      latch_empty(VEC[i][35]);
      do_req(VEC[i][32:1], VEC[i][34:33]);
      chk($sformatf("vector %0d (R5/R6/R7/R8)", i), VEC[i][0], ~VEC[i][0]);
    end

    @(negedge clk);
    chk("R2 idle cycle", 1'b0, 1'b0);

    // R4: flag changes outside a bus write cycle are ignored
    latch_empty(1'b0);
    ext_empty_n = 1'b1;
    repeat (3) @(negedge clk);
    do_req(32'h500, 2'b11);
    chk("R4 unsampled flag ignored", 1'b1, 1'b0);
    latch_empty(1'b1);
    do_req(32'h500, 2'b11);
    chk("R4 sampled flag honoured", 1'b0, 1'b1);

    // R3 / R9: ordering against outstanding external writes
    latch_empty(1'b0);
    pulse_issue(2);
    do_req(32'h100, 2'b01);
    chk("R3 outstanding stalls shared", 1'b0, 1'b1);
    pulse_done(1);
    do_req(32'h100, 2'b00);
    chk("R9 count one left", 1'b0, 1'b1);
    bus_wr_issue = 1'b1; bus_wr_done = 1'b1;
    @(negedge clk);
    bus_wr_issue = 1'b0; bus_wr_done = 1'b0;
    do_req(32'h100, 2'b00);
    chk("R9 issue and done together", 1'b0, 1'b1);
    pulse_done(1);
    do_req(32'h100, 2'b11);
    chk("R9 all done commits", 1'b1, 1'b0);
    pulse_done(1);
    pulse_issue(1);
    do_req(32'h100, 2'b00);
    chk("R9 no underflow", 1'b0, 1'b1);
    pulse_done(1);
    pulse_issue(4);
    pulse_done(2);
    do_req(32'h100, 2'b00);
    chk("R9 saturate at max", 1'b0, 1'b1);
    pulse_done(1);
    do_req(32'h100, 2'b00);
    chk("R9 drained after saturation", 1'b1, 1'b0);

    // R7: weak region bypasses outstanding writes too
    latch_empty(1'b1);
    pulse_issue(1);
    do_req(32'h0000_8004, 2'b11);
    chk("R7 weak region with outstanding", 1'b1, 1'b0);
    do_req(32'h0000_7004, 2'b00);
    chk("R3 outside region with outstanding", 1'b0, 1'b1);
    pulse_done(1);

    // R10: reprogramming entries
    cfg(3, 32'h0001_0000, 32'hFFFF_0000, 1'b1);
    do_req(32'h0001_0020, 2'b11);
    chk("R10 entry enabled", 1'b1, 1'b0);
    cfg(0, 32'h0000_8000, 32'hFFFF_F000, 1'b0);
    do_req(32'h0000_8ABC, 2'b11);
    chk("R10 entry disabled", 1'b0, 1'b1);

    @(negedge clk);
    chk("R2 idle after request", 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule